// File: doc/BRIEF.md
# Programmed I/O Device Controller

This block is the peripheral end of a processor-controlled I/O bus. Each bus cycle, the processor places a 6-bit device code on the select lines and raises up to three timing pulses. The block compares the code with its own fixed address. On a match, it turns each pulse into a local command: test the flag, clear the flag, or transfer a word.

A 12-bit buffer holds the word being moved. A direction parameter sets which way the word moves:

- **Input device:** a peripheral writes the buffer and signals done. The transfer command gates the buffer onto the return data lines.
- **Output device:** the transfer command loads the buffer from the processor's data lines. The buffer is then offered to the peripheral.

A single ready flag does three jobs. It feeds the skip answer, it drives the interrupt request, and it tells the peripheral handshake when a word is done. Skip, interrupt and return data are zero whenever this device is not driving them, so many controllers can share the lines through an OR.

Top module: `pio_dev_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the flag, the buffer and the peripheral request. After reset, `irq_o`, `dev_req` and `bus_din` are all 0.
- R2: Commands act only when `sel_code` equals the `DEV_ADDR` parameter. Pulses that arrive with any other code change no state. While the device is not selected, `skip_o` and `bus_din` are 0.
- R3: `skip_o` is 1 in the same cycle that `pulse1` is high with a matching code and the flag is set. Otherwise it is 0.
- R4: `irq_o` always equals the flag. A high `dev_done` sets the flag at the next clock edge.
- R5: `pulse2` with a matching code clears the flag and the buffer at the next edge. In input mode it also raises `dev_req` to ask the peripheral for a word.
- R6: If a clear command and `dev_done` occur in the same cycle, the clear wins. The flag and the buffer end up 0, and the word offered with `dev_done` is dropped.
- R7: In input mode (`IS_INPUT`=1), `dev_done` loads `dev_data_in` into the buffer and lowers `dev_req` at the next edge. `pulse4` with a matching code drives the buffer onto `bus_din` in the same cycle.
- R8: In output mode (`IS_INPUT`=0), `pulse4` with a matching code loads `bus_dout` into the buffer and raises `dev_req` at the next edge. `dev_data_out` shows the buffer, `bus_din` stays 0, and `dev_done` lowers `dev_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_code | input | SEL_W (6) | Device code from the processor |
| pulse1 | input | 1 | Timing pulse for the test-flag command |
| pulse2 | input | 1 | Timing pulse for the clear command |
| pulse4 | input | 1 | Timing pulse for the transfer command |
| bus_dout | input | DATA_W (12) | Data from the processor |
| bus_din | output | DATA_W (12) | Gated data to the processor; 0 when not driving |
| skip_o | output | 1 | Skip answer, for ORing onto the shared skip line |
| irq_o | output | 1 | Interrupt request, for ORing onto the shared request line |
| dev_done | input | 1 | Peripheral signals that a word transfer is complete |
| dev_data_in | input | DATA_W (12) | Word from the peripheral (input mode) |
| dev_data_out | output | DATA_W (12) | Buffered word for the peripheral (output mode); 0 in input mode |
| dev_req | output | 1 | Request to the peripheral for the next transfer |

## Verification
The flag is visible on `irq_o` every cycle. A flag that is set wrongly, or not cleared, therefore shows up one edge after the command or `dev_done` that caused it. A corrupted buffer stays hidden in input mode until the next selected `pulse4`, when `bus_din` exposes it in that same cycle. For that reason the bench follows every clear or peripheral load with a read. A decode fault that lets a wrong code through shows up as state that has changed at the next selected read or skip test.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DEF_SEL_W  = 6;
  localparam int DEF_DATA_W = 12;

  // Local command = select match AND timing pulse.
  function automatic logic cmd_gate(input logic hit, input logic pulse);
    return hit & pulse;
  endfunction

  // Next flag value: clear has priority over the done event.
  function automatic logic flag_next(input logic cur, input logic clr, input logic done);
    if (clr)       return 1'b0;
    else if (done) return 1'b1;
    else           return cur;
  endfunction
endpackage

// File: rtl/pio_sel_decode.sv
module pio_sel_decode #(
  parameter int SEL_W = 6,
  parameter logic [SEL_W-1:0] DEV_ADDR = '0
) (
  input  logic [SEL_W-1:0] sel_code,
  input  logic             pulse1,
  input  logic             pulse2,
  input  logic             pulse4,
  output logic             hit,
  output logic             cmd_test,
  output logic             cmd_clear,
  output logic             cmd_xfer
);
  import pio_pkg::*;
  assign hit       = (sel_code == DEV_ADDR);
  assign cmd_test  = cmd_gate(hit, pulse1);
  assign cmd_clear = cmd_gate(hit, pulse2);
  assign cmd_xfer  = cmd_gate(hit, pulse4);
endmodule

// File: rtl/pio_flag_ctrl.sv
module pio_flag_ctrl #(
  parameter bit IS_INPUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_clear,
  input  logic cmd_xfer,
  input  logic dev_done,
  output logic flag_q,
  output logic req_q
);
  import pio_pkg::*;
  logic req_set;
  // Input devices ask for a word on clear; output devices after a load.
  assign req_set = IS_INPUT ? cmd_clear : cmd_xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, cmd_clear, dev_done);
      if (req_set)       req_q <= 1'b1;
      else if (dev_done) req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_data_buf.sv
module pio_data_buf #(
  parameter int DATA_W   = 12,
  parameter bit IS_INPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_clear,
  input  logic              cmd_xfer,
  input  logic              dev_done,
  input  logic [DATA_W-1:0] dev_data_in,
  input  logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] buf_q
);
  logic              load_en;
  logic              clr_en;
  logic [DATA_W-1:0] load_word;

  // Direction picks the source of the word and the event that loads it.
  assign load_word = IS_INPUT ? dev_data_in : bus_dout;
  assign load_en   = IS_INPUT ? (dev_done & ~cmd_clear) : cmd_xfer;
  assign clr_en    = IS_INPUT ? cmd_clear : (cmd_clear & ~cmd_xfer);

  always_ff @(posedge clk) begin
    if (rst)          buf_q <= '0;
    else if (clr_en)  buf_q <= '0;
    else if (load_en) buf_q <= load_word;
  end
endmodule

// File: rtl/pio_dev_ctrl.sv
module pio_dev_ctrl #(
  parameter int SEL_W    = pio_pkg::DEF_SEL_W,
  parameter int DATA_W   = pio_pkg::DEF_DATA_W,
  parameter logic [SEL_W-1:0] DEV_ADDR = 3,
  parameter bit IS_INPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_code,
  input  logic              pulse1,
  input  logic              pulse2,
  input  logic              pulse4,
  input  logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] bus_din,
  output logic              skip_o,
  output logic              irq_o,
  input  logic              dev_done,
  input  logic [DATA_W-1:0] dev_data_in,
  output logic [DATA_W-1:0] dev_data_out,
  output logic              dev_req
);
  logic              hit, cmd_test, cmd_clear, cmd_xfer;
  logic              flag_q, req_q;
  logic [DATA_W-1:0] buf_q;

  pio_sel_decode #(.SEL_W(SEL_W), .DEV_ADDR(DEV_ADDR)) u_dec (
    .sel_code(sel_code), .pulse1(pulse1), .pulse2(pulse2), .pulse4(pulse4),
    .hit(hit), .cmd_test(cmd_test), .cmd_clear(cmd_clear), .cmd_xfer(cmd_xfer)
  );

  pio_flag_ctrl #(.IS_INPUT(IS_INPUT)) u_flag (
    .clk(clk), .rst(rst), .cmd_clear(cmd_clear), .cmd_xfer(cmd_xfer),
    .dev_done(dev_done), .flag_q(flag_q), .req_q(req_q)
  );

  pio_data_buf #(.DATA_W(DATA_W), .IS_INPUT(IS_INPUT)) u_buf (
    .clk(clk), .rst(rst), .cmd_clear(cmd_clear), .cmd_xfer(cmd_xfer),
    .dev_done(dev_done), .dev_data_in(dev_data_in), .bus_dout(bus_dout),
    .buf_q(buf_q)
  );

  // Open-collector style outputs: zero unless this device drives them.
  assign skip_o       = cmd_test & flag_q;
  assign irq_o        = flag_q;
  assign bus_din      = IS_INPUT ? ({DATA_W{cmd_xfer}} & buf_q) : '0;
  assign dev_data_out = IS_INPUT ? '0 : buf_q;
  assign dev_req      = req_q;
endmodule

// File: rtl/pio_dev_ctrl_chk.sv
module pio_dev_ctrl_chk #(
  parameter int DATA_W   = 12,
  parameter bit IS_INPUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              hit,
  input logic              cmd_test,
  input logic              cmd_clear,
  input logic              cmd_xfer,
  input logic              dev_done,
  input logic              flag_q,
  input logic              req_q,
  input logic              skip_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] bus_din
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!flag_q && !req_q));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!skip_o && bus_din == '0));

  assert_skip_source_R3: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> (cmd_test && flag_q));

  assert_done_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (dev_done && !cmd_clear) |=> irq_o);

  assert_clear_flag_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_clear |=> !irq_o);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_clear && dev_done) |=> !flag_q);

  assert_done_drops_req_R7: assert property (@(posedge clk) disable iff (rst)
    (IS_INPUT && dev_done && !cmd_clear) |=> !req_q);

  assert_load_requests_R8: assert property (@(posedge clk) disable iff (rst)
    (!IS_INPUT && cmd_xfer) |=> req_q);
endmodule

bind pio_dev_ctrl pio_dev_ctrl_chk #(.DATA_W(DATA_W), .IS_INPUT(IS_INPUT)) u_chk (
  .clk(clk), .rst(rst), .hit(hit), .cmd_test(cmd_test), .cmd_clear(cmd_clear),
  .cmd_xfer(cmd_xfer), .dev_done(dev_done), .flag_q(flag_q), .req_q(req_q),
  .skip_o(skip_o), .irq_o(irq_o), .bus_din(bus_din)
);

// File: tb/pio_dev_ctrl_test.sv
module pio_dev_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  sel_code = '0;
  logic        pulse1 = 0, pulse2 = 0, pulse4 = 0;
  logic [11:0] bus_dout = '0;
  logic        done_i = 0, done_o = 0;
  logic [11:0] data_i = '0;
  logic [11:0] din_i, din_o, dout_i, dout_o;
  logic        skip_i, skip_o2, irq_i, irq_o2, req_i, req_o;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  pio_dev_ctrl #(.DEV_ADDR(6'd3), .IS_INPUT(1'b1)) uut (
    .clk(clk), .rst(rst), .sel_code(sel_code), .pulse1(pulse1), .pulse2(pulse2),
    .pulse4(pulse4), .bus_dout(bus_dout), .bus_din(din_i), .skip_o(skip_i),
    .irq_o(irq_i), .dev_done(done_i), .dev_data_in(data_i),
    .dev_data_out(dout_i), .dev_req(req_i));

  pio_dev_ctrl #(.DEV_ADDR(6'd4), .IS_INPUT(1'b0)) uut_o (
    .clk(clk), .rst(rst), .sel_code(sel_code), .pulse1(pulse1), .pulse2(pulse2),
    .pulse4(pulse4), .bus_dout(bus_dout), .bus_din(din_o), .skip_o(skip_o2),
    .irq_o(irq_o2), .dev_done(done_o), .dev_data_in(12'h000),
    .dev_data_out(dout_o), .dev_req(req_o));

  typedef struct packed {
    logic [5:0]  sel;
    logic        p1, p2, p4, done;
    logic [11:0] ddata;
    logic        e_skip, e_irq;
    logic [11:0] e_din;
    logic        e_req;
    logic [3:0]  rq;
  } vec_t;

  // Expected values are the outputs seen in the step itself, before its edge.
  localparam vec_t VEC [15] = '{
    '{6'd3, 1'b1,1'b0,1'b0,1'b0, 12'h000, 1'b0,1'b0, 12'h000, 1'b0, 4'd3}, // R3 flag clear, no skip
    '{6'd3, 1'b0,1'b1,1'b0,1'b0, 12'h000, 1'b0,1'b0, 12'h000, 1'b0, 4'd5}, // R5 clear, request
    '{6'd0, 1'b0,1'b0,1'b0,1'b1, 12'hA5C, 1'b0,1'b0, 12'h000, 1'b1, 4'd5}, // R5 req up; R7 load
    '{6'd3, 1'b1,1'b0,1'b0,1'b0, 12'h000, 1'b1,1'b1, 12'h000, 1'b0, 4'd3}, // R3 skip; R4 irq; R7 req down
    '{6'd5, 1'b1,1'b0,1'b0,1'b0, 12'h000, 1'b0,1'b1, 12'h000, 1'b0, 4'd2}, // R2 wrong code
    '{6'd3, 1'b0,1'b0,1'b1,1'b0, 12'h000, 1'b0,1'b1, 12'hA5C, 1'b0, 4'd7}, // R7 read
    '{6'd2, 1'b0,1'b0,1'b1,1'b0, 12'h000, 1'b0,1'b1, 12'h000, 1'b0, 4'd2}, // R2 no read
    '{6'd7, 1'b0,1'b1,1'b0,1'b0, 12'h000, 1'b0,1'b1, 12'h000, 1'b0, 4'd2}, // R2 clear ignored
    '{6'd3, 1'b0,1'b0,1'b1,1'b0, 12'h000, 1'b0,1'b1, 12'hA5C, 1'b0, 4'd2}, // R2 buffer intact
    '{6'd3, 1'b0,1'b1,1'b0,1'b1, 12'h123, 1'b0,1'b1, 12'h000, 1'b0, 4'd6}, // R6 clear + done
    '{6'd3, 1'b0,1'b0,1'b1,1'b0, 12'h000, 1'b0,1'b0, 12'h000, 1'b1, 4'd6}, // R6 clear won
    '{6'd3, 1'b1,1'b0,1'b0,1'b0, 12'h000, 1'b0,1'b0, 12'h000, 1'b1, 4'd6}, // R6 no skip
    '{6'd0, 1'b0,1'b0,1'b0,1'b1, 12'hFFF, 1'b0,1'b0, 12'h000, 1'b1, 4'd4}, // R4 done
    '{6'd3, 1'b0,1'b0,1'b1,1'b0, 12'h000, 1'b0,1'b1, 12'hFFF, 1'b0, 4'd4}, // R4 irq; R7 all ones
    '{6'd3, 1'b1,1'b0,1'b0,1'b0, 12'h000, 1'b1,1'b1, 12'h000, 1'b0, 4'd3}  // R3 skip again
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] s, input logic a, input logic b, input logic c,
                       input logic di, input logic [11:0] dd, input logic doo, input logic [11:0] bo);
    @(negedge clk);
    sel_code = s; pulse1 = a; pulse2 = b; pulse4 = c;
    done_i = di; data_i = dd; done_o = doo; bus_dout = bo;
    #1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "irq after reset", irq_i, 0);
    chk("R1", "req after reset", req_i, 0);
    chk("R1", "out irq after reset", irq_o2, 0);

    for (int i = 0; i < 15; i++) begin
      string t;
      t = $sformatf("R%0d", VEC[i].rq);
      drive(VEC[i].sel, VEC[i].p1, VEC[i].p2, VEC[i].p4, VEC[i].done, VEC[i].ddata, 1'b0, 12'h000);
      chk(t, "skip", skip_i, VEC[i].e_skip);
      chk(t, "irq", irq_i, VEC[i].e_irq);
      chk(t, "bus_din", din_i, VEC[i].e_din);
      chk(t, "dev_req", req_i, VEC[i].e_req);
    end

    // R1: reset with the flag set and the buffer full
    drive(6'd0, 0, 0, 0, 0, 12'h000, 0, 12'h000);
    rst = 1'b1;
    drive(6'd0, 0, 0, 0, 0, 12'h000, 0, 12'h000);
    rst = 1'b0;
    #1;
    chk("R1", "irq cleared", irq_i, 0);
    chk("R1", "req cleared", req_i, 0);
    drive(6'd3, 0, 0, 1, 0, 12'h000, 0, 12'h000);
    chk("R1", "buffer cleared", din_i, 0);

    // R8: output device at address 4
    drive(6'd4, 0, 0, 1, 0, 12'h000, 0, 12'h3C7);
    chk("R8", "no return data", din_o, 0);
    chk("R2", "input dev not selected", din_i, 0);
    drive(6'd0, 0, 0, 0, 0, 12'h000, 0, 12'h000);
    chk("R8", "dev_data_out", dout_o, 12'h3C7);
    chk("R8", "dev_req raised", req_o, 1);
    chk("R8", "irq still low", irq_o2, 0);
    chk("R2", "input dev irq", irq_i, 0);
    drive(6'd0, 0, 0, 0, 0, 12'h000, 1, 12'h000);
    drive(6'd4, 1, 0, 0, 0, 12'h000, 0, 12'h000);
    chk("R8", "done drops req", req_o, 0);
    chk("R4", "out flag set", irq_o2, 1);
    chk("R3", "out skip", skip_o2, 1);
    chk("R2", "input dev no skip", skip_i, 0);
    drive(6'd4, 0, 1, 0, 0, 12'h000, 0, 12'h000);
    drive(6'd0, 0, 0, 0, 0, 12'h000, 0, 12'h000);
    chk("R5", "out flag cleared", irq_o2, 0);
    chk("R5", "out buffer cleared", dout_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule